// File: doc/BRIEF.md
# Auto-Sequencing I2C Slave Register Port

This block is the slave-only serial front end of a small port-expander function. It oversamples the I2C clock and data lines with a fast system clock, so it works at either 100 kbit/s or 400 kbit/s. It detects start, repeated start and stop conditions. It answers one 7-bit address, and a strap input picks that address from two fixed values.

A write transfer carries exactly one payload byte. The two top bits of that byte name the target register, and the six low bits are its new contents. The block does not hold the target registers. It issues a one-cycle write strobe with a register select and the payload, and the surrounding logic performs the store. It also issues a one-cycle strobe on every stop condition, which the neighbouring output multiplexer uses as its update point.

A read transfer streams bytes in a fixed order: register A, then register B, then a snapshot of the parallel input pins. The first two come from the block's inputs. The snapshot is taken on the first SCL rise after each start.

Top module: `i2c_regport_slave`

State machine states:
- `S_IDLE`: the bus is free.
- `S_ADDR`: the address byte is being shifted in.
- `S_AACK`: the block drives the address acknowledge.
- `S_WDAT`: the payload byte is being shifted in.
- `S_WACK`: the block drives the payload acknowledge.
- `S_RDAT`: a read byte is being shifted out.
- `S_RACK`: the block samples the master's acknowledge.
- `S_SKIP`: SDA is released until the next condition.

Transitions:
- Any state goes to `S_IDLE` on a stop and to `S_ADDR` on a start.
- `S_ADDR` goes to `S_AACK` on the fall after the eighth bit when the address hits, and to `S_SKIP` when it misses.
- `S_AACK` goes to `S_RDAT` or `S_WDAT` by the R/W bit.
- `S_WDAT` goes to `S_WACK` for a valid target and to `S_SKIP` otherwise.
- `S_WACK` goes to `S_SKIP`.
- `S_RDAT` goes to `S_RACK` after the eighth bit.
- `S_RACK` goes to `S_RDAT` on a master ACK and to `S_SKIP` on a NACK.

## Requirements
- R1: After reset SDA is released and no strobe is active. Every stop condition (SDA rising while SCL is high) gives exactly one `stop_stb` pulse. A start condition (SDA falling while SCL is high) begins a new address byte.
- R2: The block acknowledges the address byte by pulling SDA low during the ninth clock. The address it answers is 1001110 when `addr_sel` is 1 and 0110111 when `addr_sel` is 0.
- R3: Any other address is not acknowledged, including the general call address 0000000. After such an address, SDA stays released for the rest of the transfer and no write strobe is produced.
- R4: In a write payload byte, bits 7:6 equal to 00 target register A (`wr_sel`=0) and bits 7:6 equal to 01 target register B (`wr_sel`=1). Bits 5:0 appear on `wr_data`. The byte is acknowledged, and `wr_stb` pulses for one cycle.
- R5: A payload byte whose bits 7:6 are 10 or 11 is not acknowledged and produces no strobe.
- R6: Only one payload byte is accepted per addressed write. A following byte is not acknowledged and does not strobe.
- R7: A read returns `rega_val`, then `regb_val`, then the snapshot byte. A read that continues past the third byte wraps back to `rega_val`.
- R8: A master NACK followed by a stop after the first byte ends the read with only register A sent. The next read starts again at register A.
- R9: The snapshot byte is 000 in bits 7:5 and `port_in` in bits 4:0. It is captured on the first SCL rise after a start. Pin changes after that point do not appear until the next start.
- R10: Reads are non-destructive. They produce no write strobe, and repeating a read gives the same bytes.
- R11: A repeated start with no stop in between is accepted. For example, a read followed directly by an addressed write performs the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Sampled level of the SCL line |
| sda_in | input | 1 | Sampled level of the SDA line |
| addr_sel | input | 1 | Strap that picks one of the two slave addresses |
| port_in | input | PORT_W | Parallel input pins to be snapshotted |
| rega_val | input | 8 | Byte returned for register A |
| regb_val | input | 8 | Byte returned for register B |
| sda_drive_low | output | 1 | 1 pulls SDA low; 0 releases it |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_sel | output | 1 | Write target: 0 is register A, 1 is register B |
| wr_data | output | 6 | New register contents |
| stop_stb | output | 1 | One-cycle pulse on each stop condition |

## Verification
The bench uses the default parameters: a five-bit input port, two synchroniser stages and the two fixed addresses. With these defaults the snapshot carries three zero padding bits, and the two-bit read index must wrap from its third value back to zero. Driving the strap both ways reaches both address matches. It also reaches the cross case, where one strap value is used with the other strap's address. The bus is modelled as a wired AND of the master and the block, so the acknowledge and data phases are observed on the shared line.

// File: rtl/i2c_rp_pkg.sv
package i2c_rp_pkg;
    localparam int BYTE_W   = 8;
    localparam int DATA_W   = BYTE_W - 2;
    localparam int CNT_W    = 4;
    localparam int RD_BYTES = 3;
    localparam int IDX_W    = $clog2(RD_BYTES);

    typedef enum logic [2:0] {
        S_IDLE, S_ADDR, S_AACK, S_WDAT, S_WACK, S_RDAT, S_RACK, S_SKIP
    } rp_state_e;
endpackage

// File: rtl/i2c_rp_sync.sv
module i2c_rp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2c_rp_cond.sv
module i2c_rp_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl;
            sda_d <= sda;
        end
    end

    assign scl_rise  = scl & ~scl_d;
    assign scl_fall  = ~scl & scl_d;
    assign start_det = scl & scl_d & sda_d & ~sda;
    assign stop_det  = scl & scl_d & ~sda_d & sda;
endmodule

// File: rtl/i2c_regport_slave.sv
module i2c_regport_slave
    import i2c_rp_pkg::*;
#(
    parameter logic [6:0] ADDR_HI     = 7'b1001110,
    parameter logic [6:0] ADDR_LO     = 7'b0110111,
    parameter int         PORT_W      = 5,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              addr_sel,
    input  logic [PORT_W-1:0] port_in,
    input  logic [7:0]        rega_val,
    input  logic [7:0]        regb_val,
    output logic              sda_drive_low,
    output logic              wr_stb,
    output logic              wr_sel,
    output logic [5:0]        wr_data,
    output logic              stop_stb
);
    localparam int PAD_W = BYTE_W - PORT_W;

    logic [1:0] line_raw, line_s;
    logic       scl_s, sda_s;
    logic       scl_rise, scl_fall, start_det, stop_det;

    assign line_raw = {scl_in, sda_in};

    generate
        for (genvar g = 0; g < 2; g++) begin : g_sync
            i2c_rp_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk(clk), .rst_n(rst_n), .d(line_raw[g]), .q(line_s[g])
            );
        end
    endgenerate

    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    i2c_rp_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl(scl_s), .sda(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    rp_state_e          state, state_n;
    logic [BYTE_W-1:0]  shreg, tx, snap_q, next_byte;
    logic [CNT_W-1:0]   bit_cnt;
    logic [IDX_W-1:0]   rd_idx, nxt_idx;
    logic               mst_ack, snap_arm, addr_hit, dest_ok;

    assign addr_hit = (shreg[7:1] == (addr_sel ? ADDR_HI : ADDR_LO));
    assign dest_ok  = ~shreg[7];

    always_comb begin
        nxt_idx = (rd_idx == IDX_W'(RD_BYTES - 1)) ? '0 : rd_idx + 1'b1;
        case (nxt_idx)
            IDX_W'(0): next_byte = rega_val;
            IDX_W'(1): next_byte = regb_val;
            default:   next_byte = snap_q;
        endcase
    end

    // next-state logic
    always_comb begin
        state_n = state;
        if (stop_det)       state_n = S_IDLE;
        else if (start_det) state_n = S_ADDR;
        else begin
            unique case (state)
                S_IDLE, S_SKIP: state_n = state;
                S_ADDR: if (scl_fall && bit_cnt == CNT_W'(8))
                            state_n = addr_hit ? S_AACK : S_SKIP;
                S_AACK: if (scl_fall) state_n = shreg[0] ? S_RDAT : S_WDAT;
                S_WDAT: if (scl_fall && bit_cnt == CNT_W'(8))
                            state_n = dest_ok ? S_WACK : S_SKIP;
                S_WACK: if (scl_fall) state_n = S_SKIP;
                S_RDAT: if (scl_fall && bit_cnt == CNT_W'(7)) state_n = S_RACK;
                S_RACK: if (scl_fall) state_n = mst_ack ? S_RDAT : S_SKIP;
                default: state_n = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_drive_low <= 1'b0;
            wr_stb        <= 1'b0;
            wr_sel        <= 1'b0;
            wr_data       <= '0;
            stop_stb      <= 1'b0;
            shreg         <= '0;
            tx            <= '0;
            bit_cnt       <= '0;
            rd_idx        <= '0;
            mst_ack       <= 1'b0;
            snap_q        <= '0;
            snap_arm      <= 1'b0;
        end else begin
            wr_stb   <= 1'b0;
            stop_stb <= stop_det;
            if (start_det) snap_arm <= 1'b1;
            else if (snap_arm && scl_rise) begin
                snap_q   <= {{PAD_W{1'b0}}, port_in};
                snap_arm <= 1'b0;
            end
            if (stop_det || start_det) begin
                sda_drive_low <= 1'b0;
                bit_cnt       <= '0;
            end else begin
                unique case (state)
                    S_ADDR, S_WDAT: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == CNT_W'(8)) begin
                            if (state == S_ADDR) sda_drive_low <= addr_hit;
                            else if (dest_ok) begin
                                sda_drive_low <= 1'b1;
                                wr_stb        <= 1'b1;
                                wr_sel        <= shreg[6];
                                wr_data       <= shreg[DATA_W-1:0];
                            end
                        end
                    end
                    S_AACK: if (scl_fall) begin
                        bit_cnt <= '0;
                        if (shreg[0]) begin
                            tx            <= rega_val;
                            rd_idx        <= '0;
                            sda_drive_low <= ~rega_val[7];
                        end else sda_drive_low <= 1'b0;
                    end
                    S_WACK: if (scl_fall) sda_drive_low <= 1'b0;
                    S_RDAT: if (scl_fall) begin
                        if (bit_cnt == CNT_W'(7)) begin
                            sda_drive_low <= 1'b0;
                            bit_cnt       <= '0;
                        end else begin
                            tx            <= {tx[BYTE_W-2:0], 1'b0};
                            sda_drive_low <= ~tx[BYTE_W-2];
                            bit_cnt       <= bit_cnt + 1'b1;
                        end
                    end
                    S_RACK: begin
                        if (scl_rise) mst_ack <= ~sda_s;
                        else if (scl_fall && mst_ack) begin
                            tx            <= next_byte;
                            rd_idx        <= nxt_idx;
                            sda_drive_low <= ~next_byte[7];
                        end
                    end
                    S_IDLE, S_SKIP: sda_drive_low <= 1'b0;
                    default: sda_drive_low <= 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk
    import i2c_rp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input rp_state_e  st,
    input logic       sda_drive_low,
    input logic       wr_stb,
    input logic       stop_stb,
    input logic [7:0] snap_q,
    input logic       snap_arm
);
    assert_drive_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sda_drive_low |-> (st == S_AACK || st == S_WACK || st == S_RDAT));

    assert_strobe_in_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> st == S_WACK);

    assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    assert_stop_to_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_stb |-> st == S_IDLE);

    assert_snap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(snap_q) |-> $past(snap_arm));

    assert_read_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RDAT || st == S_RACK) |-> !wr_stb);
endmodule

bind i2c_regport_slave i2c_regport_chk u_chk (
    .clk(clk), .rst_n(rst_n), .st(state), .sda_drive_low(sda_drive_low),
    .wr_stb(wr_stb), .stop_stb(stop_stb), .snap_q(snap_q), .snap_arm(snap_arm)
);

// File: tb/tb_i2c_regport_slave.sv
module tb_i2c_regport_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 20;

    // [31] strap, [30:24] address, [23:16] payload,
    // [2] expect address ACK, [1] expect payload ACK, [0] expect strobe
    localparam logic [31:0] VEC [0:7] = '{
        32'hCE15_0007, 32'hCE6A_0007, 32'h373F_0007, 32'h4E15_0000,
        32'hB715_0000, 32'h8015_0000, 32'hCE80_0004, 32'h37C1_0004
    };

    logic clk = 1'b0;
    logic rst_n;
    logic scl_m, sda_m, addr_sel;
    logic [4:0] port_in;
    logic [7:0] rega_val, regb_val;
    logic sda_drive_low, wr_stb, wr_sel, stop_stb;
    logic [5:0] wr_data;
    logic sda_line;

    int checks = 0, fails = 0, wr_cnt = 0, stop_cnt = 0;
    logic last_sel;
    logic [5:0] last_data;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_line = sda_m & ~sda_drive_low;

    i2c_regport_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .addr_sel(addr_sel), .port_in(port_in), .rega_val(rega_val),
        .regb_val(regb_val), .sda_drive_low(sda_drive_low), .wr_stb(wr_stb),
        .wr_sel(wr_sel), .wr_data(wr_data), .stop_stb(stop_stb)
    );

    always @(posedge clk) if (rst_n) begin
        if (wr_stb) begin
            wr_cnt    <= wr_cnt + 1;
            last_sel  <= wr_sel;
            last_data <= wr_data;
        end
        if (stop_stb) stop_cnt <= stop_cnt + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; scl_m = 1'b0; wq();
    endtask

    task automatic write_byte(input logic [7:0] v, output logic ack);
        logic line;
        for (int k = 7; k >= 0; k--) send_bit(v[k]);
        recv_bit(line);
        ack = ~line;
    endtask

    task automatic read_byte(input logic ack, output logic [7:0] v);
        logic line;
        v = '0;
        for (int k = 0; k < 8; k++) begin
            recv_bit(line);
            v = {v[6:0], line};
        end
        send_bit(~ack);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] b;
        int wc0, sc0;
        scl_m = 1'b1; sda_m = 1'b1; addr_sel = 1'b1; port_in = 5'h13;
        rega_val = 8'hA5; regb_val = 8'h5C; rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset sda", {31'b0, sda_drive_low}, 0);
        chk("R1 reset wr_stb", {31'b0, wr_stb}, 0);
        chk("R1 reset stop_stb", {31'b0, stop_stb}, 0);

        // write vectors: R2 R3 R4 R5 and stop pulses R1
        for (int i = 0; i < 8; i++) begin
            logic [31:0] v;
            v = VEC[i];
            addr_sel = v[31];
            wc0 = wr_cnt; sc0 = stop_cnt;
            i2c_start();
            write_byte({v[30:24], 1'b0}, ack);
            chk("R2/R3 address ack", {31'b0, ack}, {31'b0, v[2]});
            write_byte(v[23:16], ack);
            chk("R4/R5 payload ack", {31'b0, ack}, {31'b0, v[1]});
            i2c_stop(); wq();
            chk("R4/R5 strobe count", wr_cnt - wc0, {31'b0, v[0]});
            if (v[0]) begin
                chk("R4 wr_sel", {31'b0, last_sel}, {31'b0, v[22]});
                chk("R4 wr_data", {26'b0, last_data}, {26'b0, v[21:16]});
            end
            chk("R1 one stop pulse", stop_cnt - sc0, 1);
        end

        // R7 order and wrap, R9 snapshot hold
        addr_sel = 1'b1; port_in = 5'h13; wc0 = wr_cnt;
        i2c_start();
        write_byte(8'h9D, ack);
        chk("R7 read address ack", {31'b0, ack}, 1);
        port_in = 5'h0A;
        read_byte(1'b1, b); chk("R7 byte A", {24'b0, b}, 32'hA5);
        read_byte(1'b1, b); chk("R7 byte B", {24'b0, b}, 32'h5C);
        read_byte(1'b1, b); chk("R9 snapshot held", {24'b0, b}, 32'h13);
        read_byte(1'b1, b); chk("R7 wrap to A", {24'b0, b}, 32'hA5);
        read_byte(1'b0, b); chk("R7 wrap then B", {24'b0, b}, 32'h5C);
        i2c_stop();

        // R8 short read, R10 repeat, R9 fresh snapshot
        i2c_start(); write_byte(8'h9D, ack);
        read_byte(1'b0, b); chk("R8 single byte A", {24'b0, b}, 32'hA5);
        i2c_stop();
        i2c_start(); write_byte(8'h9D, ack);
        read_byte(1'b1, b); chk("R8 restart at A", {24'b0, b}, 32'hA5);
        read_byte(1'b1, b); chk("R10 repeat B", {24'b0, b}, 32'h5C);
        read_byte(1'b0, b); chk("R9 new snapshot", {24'b0, b}, 32'h0A);
        i2c_stop(); wq();
        chk("R10 no strobe on reads", wr_cnt - wc0, 0);

        // R11 repeated start read then write
        i2c_start(); write_byte(8'h9D, ack);
        read_byte(1'b0, b);
        i2c_start();
        write_byte(8'h9C, ack); chk("R11 address ack after rs", {31'b0, ack}, 1);
        write_byte(8'h47, ack); chk("R11 payload ack", {31'b0, ack}, 1);
        i2c_stop(); wq();
        chk("R11 strobe", wr_cnt - wc0, 1);
        chk("R11 sel", {31'b0, last_sel}, 1);
        chk("R11 data", {26'b0, last_data}, 32'h07);

        // R6 second payload byte refused
        wc0 = wr_cnt;
        i2c_start(); write_byte(8'h9C, ack);
        write_byte(8'h05, ack); chk("R6 first byte ack", {31'b0, ack}, 1);
        write_byte(8'h06, ack); chk("R6 second byte nack", {31'b0, ack}, 0);
        i2c_stop(); wq();
        chk("R6 one strobe", wr_cnt - wc0, 1);
        chk("R6 data kept", {26'b0, last_data}, 32'h05);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule